// File: doc/BRIEF.md
# Rotating-Bank Fixed Delay Line

This block delays a multi-bit data word by a fixed number of accepted cycles. Seen from its ports, it behaves exactly like a chain of four registers in series that advances only when the enable input is high. Inside, it switches less logic than such a chain. The three leading stages are held in a small bank of slots. On each enabled cycle only one slot takes new data, and a rotating index chooses that slot.

On the same enabled cycle, the slot the index points at still holds the word written three enabled cycles earlier. A selector reads that slot into a final ordinary register, and the new word then overwrites the slot. That final register is loaded on every enabled cycle, so downstream logic sees the same clock-to-output timing as before. The per-slot write enables are the points where clock gating would be inserted. A synchronous reset clears the slots, the index and the output.

Top module: `lp_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` becomes zero on that edge. After reset, `dout` stays zero through the first three enabled cycles.
- R2: A word taken on enabled edge n appears on `dout` right after enabled edge n+3. This matches four registers in series, with disabled cycles not counted.
- R3: A cycle with `en` low changes nothing. The slots and index are left as they were, which shows as an unbroken enabled sequence afterwards.
- R4: In any cycle at most one slot write enable is asserted. Exactly one is asserted when `en` is high.
- R5: The rotating index takes the values 0, 1, 2 and then wraps to 0. It advances by one only on enabled cycles.
- R6: `dout` changes only at a rising edge where `en` or `rst` is high.
- R7: A slot whose write enable is low keeps its contents through that edge.
- R8: A reset in the middle of a stream discards all words in flight. The next three enabled cycles give zero, and the fourth gives the first word taken after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accept a word and advance the line |
| din | input | WIDTH | Data word entering the line |
| dout | output | WIDTH | Data word delayed by four enabled cycles |

## Verification
A short fixed table first feeds distinct, easy-to-read words, with stall cycles in between. It shows the three leading zero outputs after reset, and it shows that a stall neither advances the index nor skips a slot. A long run of random words and random enables is then compared against a plain four-register shift model. Any slip in the rotation order, or a read taken after the overwrite instead of before it, shows up there as an off-by-one latency. A final reset issued while full words are still in flight tells true clearing of the slots apart from merely clearing the output register.

// File: rtl/lp_delay_pkg.sv
package lp_delay_pkg;
   typedef enum logic [0:0] {
      SEL_INDEXED = 1'b0,
      SEL_ONEHOT  = 1'b1
   } sel_style_e;
endpackage

// File: rtl/rr_index.sv
module rr_index #(
   parameter int DEPTH = 3,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic [DEPTH-1:0] idx_oh
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (adv)
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign idx_oh[i] = (idx == IDX_W'(i));
   end

   p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
      idx <= LAST);
   p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
      adv |=> idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1));
   p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(idx));
endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DEPTH-1:0] wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] slots [DEPTH]
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)
            slots[i] <= '0;
         else if (wr_en[i])
            slots[i] <= wr_data;
      end

      p_slot_hold_r7: assert property (@(posedge clk) disable iff (rst)
         !wr_en[i] |=> $stable(slots[i]));
   end

   p_one_write_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_en));
endmodule

// File: rtl/slot_select.sv
module slot_select
   import lp_delay_pkg::*;
#(
   parameter int         WIDTH = 16,
   parameter int         DEPTH = 3,
   parameter sel_style_e STYLE = SEL_INDEXED,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [WIDTH-1:0] slots [DEPTH],
   input  logic [IDX_W-1:0] idx,
   input  logic [DEPTH-1:0] idx_oh,
   output logic [WIDTH-1:0] q
);
   if (STYLE == SEL_ONEHOT) begin : g_andor
      always_comb begin
         q = '0;
         for (int i = 0; i < DEPTH; i++)
            q = q | (slots[i] & {WIDTH{idx_oh[i]}});
      end
   end else begin : g_index
      logic unused_oh;
      assign unused_oh = ^idx_oh;
      always_comb begin
         q = '0;
         for (int i = 0; i < DEPTH; i++)
            if (idx == IDX_W'(i))
               q = slots[i];
      end
   end
endmodule

// File: rtl/lp_delay_line.sv
module lp_delay_line
   import lp_delay_pkg::*;
#(
   parameter int         WIDTH     = 16,
   parameter int         STAGES    = 4,
   parameter sel_style_e SEL_STYLE = SEL_INDEXED
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int BANK_DEPTH = STAGES - 1;
   localparam int IDX_W      = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

   if (STAGES < 3) begin : g_bad_stages
      $error("lp_delay_line: STAGES must be at least 3");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lp_delay_line: WIDTH must be at least 1");
   end

   logic [IDX_W-1:0]      rd_idx;
   logic [BANK_DEPTH-1:0] rd_oh;
   logic [BANK_DEPTH-1:0] wr_en;
   logic [WIDTH-1:0]      slots [BANK_DEPTH];
   logic [WIDTH-1:0]      oldest;

   rr_index #(.DEPTH(BANK_DEPTH)) u_index (
      .clk    (clk),
      .rst    (rst),
      .adv    (en),
      .idx    (rd_idx),
      .idx_oh (rd_oh)
   );

   assign wr_en = en ? rd_oh : '0;

   slot_bank #(.WIDTH(WIDTH), .DEPTH(BANK_DEPTH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (din),
      .slots   (slots)
   );

   slot_select #(.WIDTH(WIDTH), .DEPTH(BANK_DEPTH), .STYLE(SEL_STYLE)) u_sel (
      .slots  (slots),
      .idx    (rd_idx),
      .idx_oh (rd_oh),
      .q      (oldest)
   );

   always_ff @(posedge clk) begin
      if (rst)
         dout <= '0;
      else if (en)
         dout <= oldest;
   end

   p_out_clear_r1: assert property (@(posedge clk)
      rst |=> dout == '0);
   p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(dout));
   p_write_on_en_r4: assert property (@(posedge clk) disable iff (rst)
      en |-> $countones(wr_en) == 1);
endmodule

// File: tb/lp_delay_line_tb_top.sv
module lp_delay_line_tb_top;
   localparam int W = 16;
   localparam int NVEC = 12;
   // each entry: {en, din, expected dout after the edge}
   localparam logic [2*W:0] VEC [NVEC] = '{
      {1'b1, 16'h0011, 16'h0000},
      {1'b1, 16'h0022, 16'h0000},
      {1'b1, 16'h0033, 16'h0000},
      {1'b1, 16'h0044, 16'h0011},
      {1'b0, 16'h0BAD, 16'h0011},
      {1'b1, 16'h0055, 16'h0022},
      {1'b0, 16'h0BAD, 16'h0022},
      {1'b0, 16'h0BAD, 16'h0022},
      {1'b1, 16'h0066, 16'h0033},
      {1'b1, 16'h0077, 16'h0044},
      {1'b1, 16'h0088, 16'h0055},
      {1'b1, 16'h0099, 16'h0066}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   int           n_chk = 0;
   int           n_bad = 0;
   int           cyc = 0;
   bit           done = 1'b0;
   logic [W-1:0] ref_q [4];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lp_delay_line #(.WIDTH(W)) dut_i (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: dout=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // drive on falling edge, update model, sample 1 ns after the rising edge
   task automatic step(input logic r, input logic e, input logic [W-1:0] d);
      @(negedge clk);
      rst = r; en = e; din = d;
      @(posedge clk);
      if (r) begin
         for (int k = 0; k < 4; k++) ref_q[k] = '0;
      end else if (e) begin
         for (int k = 3; k > 0; k--) ref_q[k] = ref_q[k-1];
         ref_q[0] = d;
      end
      #1;
   endtask

   initial begin
      for (int k = 0; k < 4; k++) ref_q[k] = '0;
      // R1: reset with garbage input applied
      step(1'b1, 1'b1, 16'hDEAD);
      step(1'b1, 1'b1, 16'hBEEF);
      check("R1 reset", dout, '0);

      // table: R1 leading zeros, R2 latency, R3/R6 stalls
      for (int i = 0; i < NVEC; i++) begin
         step(1'b0, VEC[i][2*W], VEC[i][2*W-1:W]);
         check(VEC[i][2*W] ? ((i < 3) ? "R1 zeros" : "R2 latency") : "R3 R6 stall hold",
               dout, VEC[i][W-1:0]);
      end

      // random stream vs four-register model: R2 R3 R5 R6 R7
      for (int i = 0; i < 400; i++) begin
         step(1'b0, ($urandom % 10) < 7, W'($urandom));
         check("R2 R5 R7 random", dout, ref_q[3]);
      end

      // R8: reset in mid-stream with words in flight
      step(1'b0, 1'b1, 16'hA1A1);
      step(1'b0, 1'b1, 16'hA2A2);
      step(1'b1, 1'b1, 16'hFFFF);
      check("R8 reset clears", dout, '0);
      step(1'b0, 1'b1, 16'h1234);
      check("R8 zero 1", dout, '0);
      step(1'b0, 1'b0, 16'hFFFF);
      check("R8 stall", dout, '0);
      step(1'b0, 1'b1, 16'h2345);
      check("R8 zero 2", dout, '0);
      step(1'b0, 1'b1, 16'h3456);
      check("R8 zero 3", dout, '0);
      step(1'b0, 1'b1, 16'h4567);
      check("R8 first word", dout, 16'h1234);
      step(1'b0, 1'b1, 16'h5678);
      check("R8 second word", dout, 16'h2345);

      done = 1'b1;
   end

   initial begin
      while (!done && cyc < 5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected=<5000", cyc);
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule